// File: doc/BRIEF.md
# Consecutive-Match Run Detector

This block watches two serial bit streams that advance together, one bit each per clock. On every cycle it tests whether the two current bits agree. It raises its flag once the streams have agreed for a run of `RUN_LEN` cycles in a row, and the current cycle counts as part of that run. The default run length is four.

The state is a small saturating counter. It counts matching cycles already seen and returns to zero on any disagreement. The flag combines that count with the match test for the current cycle. As a result it rises on the last cycle that completes the run. It stays high while agreement continues. It drops in the same cycle as a disagreement, with no cycle of lag.

A typical use is a lock or qualification indicator. Two copies of a signal are compared there, and a short glitch of agreement must not count as a lock.

Top module: `run_match_detector`

## Requirements
- R1: While `rst` is high, `run_hit` is 0. A rising clock edge with `rst` high clears the run count, so that the first cycle after reset begins a new run.
- R2: In any cycle where `stream_a` differs from `stream_b`, `run_hit` is 0 in that same cycle.
- R3: `run_hit` stays 0 for the first `RUN_LEN`-1 matching cycles of a run. It becomes 1 on the `RUN_LEN`-th consecutive matching cycle.
- R4: Once high, `run_hit` stays 1 for every further matching cycle, however long the run lasts. The count saturates and never wraps.
- R5: A mismatch discards the run so far. After a mismatch, `RUN_LEN` new consecutive matches are needed before `run_hit` is 1 again.
- R6: Both agreeing bit values count as a match. A run may freely mix cycles with both bits 0 and cycles with both bits 1.
- R7: With `RUN_LEN`=4, the streams a=0100111010010 and b=0000110010010, applied first bit first, give `run_hit`=0000010000111.
- R8: The parameter `RUN_LEN` (at least 2) sets the run length, and the counter width is derived from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the streams advance on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stream_a | input | 1 | First serial bit stream |
| stream_b | input | 1 | Second serial bit stream |
| run_hit | output | 1 | High when the last `RUN_LEN` cycles, the current one included, all matched |

## Verification
The bench builds two copies side by side on the same stimulus: one with the default run length of four and one with a run length of six. The copy with length four covers the sample sequence and the saturating state of a 2-bit counter. The copy with length six uses a 3-bit counter that does not fill its range. This shows whether the saturation point follows the parameter and not the counter width. It also shows whether runs of four or five matches stay below the threshold.

// File: rtl/run_match_pkg.sv
package run_match_pkg;

  // Width needed to hold counts 0 .. run_len-1.
  function automatic int unsigned cnt_width(input int unsigned run_len);
    int unsigned w;
    w = 1;
    while ((1 << w) < run_len) w++;
    return w;
  endfunction

endpackage

// File: rtl/run_match_cmp.sv
module run_match_cmp (
  input  logic bit_a,
  input  logic bit_b,
  output logic agree
);

  assign agree = ~(bit_a ^ bit_b);

endmodule

// File: rtl/run_match_counter.sv
module run_match_counter #(
  parameter int unsigned RUN_LEN = 4,
  parameter int unsigned CW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          agree,
  output logic [CW-1:0] count,
  output logic          full
);

  localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!agree) begin
      count_q <= '0;
    end else if (count_q != TOP) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;
  assign full  = (count_q == TOP);

  // R1: reset clears the count
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (count == '0));

  // R5: a mismatch empties the run
  assert_clear_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
    !agree |=> (count == '0));

  // R3: matches below the ceiling advance by one
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (agree && count != TOP) |=> (count == $past(count) + 1'b1));

  // R4: the ceiling holds, no wrap
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (agree && count == TOP) |=> (count == TOP));

endmodule

// File: rtl/run_match_detector.sv
module run_match_detector #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stream_a,
  input  logic stream_b,
  output logic run_hit
);

  import run_match_pkg::*;

  localparam int unsigned CW = cnt_width(RUN_LEN);

  logic          agree;
  logic [CW-1:0] count;
  logic          full;

  run_match_cmp u_cmp (
    .bit_a (stream_a),
    .bit_b (stream_b),
    .agree (agree)
  );

  run_match_counter #(
    .RUN_LEN (RUN_LEN),
    .CW      (CW)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .agree (agree),
    .count (count),
    .full  (full)
  );

  assign run_hit = full & agree & ~rst;

  // R2: disagreeing bits never yield a hit
  assert_low_on_differ_R2: assert property (@(posedge clk) disable iff (rst)
    (stream_a != stream_b) |-> !run_hit);

  // R1: no hit during reset
  always_comb begin
    assert_quiet_in_reset_R1: assert (!(rst === 1'b1 && run_hit === 1'b1));
  end

  // R8: a hit needs a filled counter
  assert_hit_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
    run_hit |-> (count == CW'(RUN_LEN - 1)));

endmodule

// File: tb/run_match_detector_test.sv
module run_match_detector_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa  = 1'b0;
  logic sb  = 1'b0;
  logic hit4, hit6;

  int checks = 0;
  int errors = 0;
  int run    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  run_match_detector uut (
    .clk (clk), .rst (rst), .stream_a (sa), .stream_b (sb), .run_hit (hit4)
  );

  run_match_detector #(.RUN_LEN(6)) uut_long (
    .clk (clk), .rst (rst), .stream_a (sa), .stream_b (sb), .run_hit (hit6)
  );

  function automatic bit expect_hit(input int r, input int len, input bit in_rst);
    return !in_rst && (r >= len);
  endfunction

  task automatic check(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: run_hit=%b expected %b", tag, $time, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check before the next posedge.
  task automatic step(input bit a, input bit b, input bit r, input string tag);
    int cur;
    string t4, t6;
    @(negedge clk);
    sa = a; sb = b; rst = r;
    cur = (a == b) ? run + 1 : 0;
    if (cur > 1000) cur = 1000;
    #1;
    if (tag != "") t4 = tag;
    else if (r) t4 = "R1";
    else if (a != b) t4 = "R2";
    else if (cur >= 4 && run >= 4) t4 = "R4";
    else t4 = "R3";
    t6 = (tag == "" && !r) ? "R8" : t4;
    check(t4, hit4, expect_hit(cur, 4, r));
    check(t6, hit6, expect_hit(cur, 6, r));
    run = r ? 0 : cur;
  endtask

  initial begin
    bit [12:0] wa, wb, wq;
    void'($urandom(32'd2024));
    // reset
    step(0, 0, 1, "R1");
    step(1, 1, 1, "R1");
    step(1, 0, 1, "R1");
    // sample sequence, first bit first
    wa = 13'b0100111010010;
    wb = 13'b0000110010010;
    wq = 13'b0000010000111;
    for (int i = 12; i >= 0; i--) begin
      step(wa[i], wb[i], 0, "R7");
      checks++;
      if (hit4 !== wq[i]) begin
        errors++;
        $display("FAIL R7 bit %0d: run_hit=%b expected %b", 12 - i, hit4, wq[i]);
      end
    end
    // mixed 00/11 run
    step(1, 0, 0, "R2");
    for (int i = 0; i < 8; i++) step(i[0], i[0], 0, "R6");
    // long run to test saturation
    for (int i = 0; i < 20; i++) step(1, 1, 0, "R4");
    // mismatch then partial runs
    step(0, 1, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R5");
    step(1, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(1, 1, 0, "R5");
    // reset mid-run
    step(1, 1, 1, "R1");
    for (int i = 0; i < 6; i++) step(0, 0, 0, "R1");
    // random phases with varying match bias
    for (int ph = 0; ph < 40; ph++) begin
      int bias;
      bias = 50 + int'($urandom % 48);
      for (int i = 0; i < 60; i++) begin
        bit a, b;
        a = 1'($urandom);
        b = (int'($urandom % 100) < bias) ? a : ~a;
        step(a, b, ($urandom % 500) == 0, "");
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule